// File: doc/BRIEF.md
# Two-Road Junction Signal Controller

This block sequences the lamps at a crossing of a main road and a side road. It is a Moore machine with five phases: main green, main amber, an all-red pedestrian clearance, side green and side amber. A green phase is left only when its road's own condition (a main-road demand for main green, a side-road vehicle sensor for side green) is true at the moment the phase timer has run out. Otherwise the green holds. Leaving main amber, a pending walk request sends the junction through the all-red clearance before the side road gets green. With no walk request pending, the side road gets green at once.

A down-counting phase timer is reloaded whenever the phase changes. It holds separate dwell lengths for green, amber and clearance, and reports expiry when its count is zero. The next phase and all lamp outputs come from one combinational block. That block first sets every output to its inactive value, then asserts only what the current phase needs. Unused phase codes fall back to main green.

Top module: `junction_ctrl`

## Requirements
- R1: Synchronous active-high reset forces phase 0 (main green). The timer is loaded so that the first expiry comes GREEN_TICKS cycles after reset is released. Phase codes are: 0 main green, 1 main amber, 2 all-red clearance, 3 side green, 4 side amber.
- R2: Main green moves to main amber on a clock edge only when main_demand is high and the timer has expired. In every other case it stays in main green.
- R3: Main amber moves to the all-red clearance when the timer has expired and walk_req is high.
- R4: Main amber moves straight to side green when the timer has expired and walk_req is low. Before expiry it holds.
- R5: The all-red clearance moves to side green on timer expiry and holds until then.
- R6: Side green moves to side amber only when side_sensor is high and the timer has expired. In every other case it holds.
- R7: Side amber returns to main green on timer expiry and holds until then.
- R8: After a phase change, the timer expires after exactly the dwell for the new phase: GREEN_TICKS cycles for a green, AMBER_TICKS for an amber, CLEAR_TICKS for the clearance. While a green holds past expiry, the timer stays expired.
- R9: Each road's lamp bus {red, amber, green} is one-hot in every phase. Main shows green in phase 0, amber in phase 1 and red otherwise. Side shows green in phase 3, amber in phase 4 and red otherwise.
- R10: walk_on is high only in the all-red clearance, with both roads red. Both greens are never lit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| main_demand | input | 1 | Main-road condition allowing main green to end |
| side_sensor | input | 1 | Side-road vehicle present |
| walk_req | input | 1 | Pending pedestrian request, sampled at main amber expiry |
| main_lamp | output | 3 | Main road lamps {red, amber, green} |
| side_lamp | output | 3 | Side road lamps {red, amber, green} |
| walk_on | output | 1 | Walk indication, clearance phase only |
| phase | output | 3 | Current phase code |

## Verification
The phase register and the timer both update on the edge that samples the inputs. The new phase, the lamps and walk_on therefore show up one cycle after the input values that decided the transition, and the lamps follow the phase in that same cycle. The bench drives each input vector just after a falling edge and compares one falling edge later. At that point a reference model, stepped once with the same vector, gives the expected phase, remaining count and lamps. Dwell lengths are checked the same way: a transition that comes one cycle early or late differs from the model in the cycle it happens. A final tally confirms that every branch, including both exits from main amber and both held greens, was actually taken.

// File: rtl/junction_pkg.sv
package junction_pkg;

    typedef enum logic [2:0] {
        PH_MAIN_GO    = 3'd0,
        PH_MAIN_AMBER = 3'd1,
        PH_CLEAR      = 3'd2,
        PH_SIDE_GO    = 3'd3,
        PH_SIDE_AMBER = 3'd4
    } phase_t;

    typedef struct packed {
        logic red;
        logic amber;
        logic green;
    } lamp_t;

    localparam lamp_t LAMP_OFF   = '{red: 1'b0, amber: 1'b0, green: 1'b0};
    localparam lamp_t LAMP_RED   = '{red: 1'b1, amber: 1'b0, green: 1'b0};
    localparam lamp_t LAMP_AMBER = '{red: 1'b0, amber: 1'b1, green: 1'b0};
    localparam lamp_t LAMP_GREEN = '{red: 1'b0, amber: 1'b0, green: 1'b1};

    // Dwell length in cycles for a phase; unused codes get the green dwell
    // because they recover to main green.
    function automatic int unsigned dwell_for(phase_t p, int unsigned g,
                                              int unsigned a, int unsigned c);
        case (p)
            PH_MAIN_AMBER, PH_SIDE_AMBER: return a;
            PH_CLEAR:                     return c;
            default:                      return g;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned x, int unsigned y,
                                         int unsigned z);
        int unsigned m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned RESET_VAL = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_W'(RESET_VAL);
        end else if (reload) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);

endmodule

// File: rtl/junction_seq.sv
module junction_seq
    import junction_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   expired,
    input  logic   main_demand,
    input  logic   side_sensor,
    input  logic   walk_req,
    output phase_t cur_phase,
    output phase_t nxt_phase,
    output lamp_t  main_lamp,
    output lamp_t  side_lamp,
    output logic   walk_on
);
    phase_t state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_MAIN_GO;
        else     state_q <= nxt_phase;
    end

    // Next phase and Moore outputs together; inactive defaults first.
    always_comb begin
        nxt_phase = state_q;
        main_lamp = LAMP_OFF;
        side_lamp = LAMP_OFF;
        walk_on   = 1'b0;
        case (state_q)
            PH_MAIN_GO: begin
                main_lamp = LAMP_GREEN;
                side_lamp = LAMP_RED;
                if (main_demand && expired) nxt_phase = PH_MAIN_AMBER;
            end
            PH_MAIN_AMBER: begin
                main_lamp = LAMP_AMBER;
                side_lamp = LAMP_RED;
                if (expired) nxt_phase = walk_req ? PH_CLEAR : PH_SIDE_GO;
            end
            PH_CLEAR: begin
                main_lamp = LAMP_RED;
                side_lamp = LAMP_RED;
                walk_on   = 1'b1;
                if (expired) nxt_phase = PH_SIDE_GO;
            end
            PH_SIDE_GO: begin
                main_lamp = LAMP_RED;
                side_lamp = LAMP_GREEN;
                if (side_sensor && expired) nxt_phase = PH_SIDE_AMBER;
            end
            PH_SIDE_AMBER: begin
                main_lamp = LAMP_RED;
                side_lamp = LAMP_AMBER;
                if (expired) nxt_phase = PH_MAIN_GO;
            end
            default: begin
                main_lamp = LAMP_RED;
                side_lamp = LAMP_RED;
                nxt_phase = PH_MAIN_GO;
            end
        endcase
    end

    assign cur_phase = state_q;

endmodule

// File: rtl/junction_ctrl.sv
module junction_ctrl
    import junction_pkg::*;
#(
    parameter int unsigned GREEN_TICKS = 8,
    parameter int unsigned AMBER_TICKS = 3,
    parameter int unsigned CLEAR_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       main_demand,
    input  logic       side_sensor,
    input  logic       walk_req,
    output logic [2:0] main_lamp,
    output logic [2:0] side_lamp,
    output logic       walk_on,
    output logic [2:0] phase
);
    localparam int unsigned MAX_DWELL = max3(GREEN_TICKS, AMBER_TICKS, CLEAR_TICKS);
    localparam int unsigned CNT_W     = (MAX_DWELL > 2) ? $clog2(MAX_DWELL) : 1;

    phase_t           cur_ph;
    phase_t           nxt_ph;
    lamp_t            m_lamp;
    lamp_t            s_lamp;
    logic             phase_done;
    logic             ph_change;
    logic [CNT_W-1:0] reload_val;

    assign ph_change  = (nxt_ph != cur_ph);
    assign reload_val = CNT_W'(dwell_for(nxt_ph, GREEN_TICKS, AMBER_TICKS, CLEAR_TICKS) - 1);

    phase_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (GREEN_TICKS - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .reload   (ph_change),
        .load_val (reload_val),
        .expired  (phase_done)
    );

    junction_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .expired     (phase_done),
        .main_demand (main_demand),
        .side_sensor (side_sensor),
        .walk_req    (walk_req),
        .cur_phase   (cur_ph),
        .nxt_phase   (nxt_ph),
        .main_lamp   (m_lamp),
        .side_lamp   (s_lamp),
        .walk_on     (walk_on)
    );

    assign main_lamp = m_lamp;
    assign side_lamp = s_lamp;
    assign phase     = cur_ph;

endmodule

// File: rtl/junction_ctrl_chk.sv
module junction_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       main_demand,
    input logic       side_sensor,
    input logic       walk_req,
    input logic       expired,
    input logic [2:0] main_lamp,
    input logic [2:0] side_lamp,
    input logic       walk_on,
    input logic [2:0] phase
);
    assert_reset_phase_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> phase == 3'd0);

    assert_main_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && !(main_demand && expired)) |=> phase == 3'd0);

    assert_main_leave_R2: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd0 && main_demand && expired) |=> phase == 3'd1);

    assert_amber_walk_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 && expired && walk_req) |=> phase == 3'd2);

    assert_amber_direct_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd1 && expired && !walk_req) |=> phase == 3'd3);

    assert_clear_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd2 && expired) |=> phase == 3'd3);

    assert_side_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd3 && !(side_sensor && expired)) |=> phase == 3'd3);

    assert_side_amber_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == 3'd4 && expired) |=> phase == 3'd0);

    assert_held_expiry_R8: assert property (@(posedge clk) disable iff (rst)
        (expired && $stable(phase) && (phase == 3'd0 || phase == 3'd3)) |=> (expired || phase != $past(phase)));

    assert_one_lamp_R9: assert property (@(posedge clk) disable iff (rst)
        ($countones(main_lamp) == 1) && ($countones(side_lamp) == 1));

    assert_no_dual_green_R10: assert property (@(posedge clk) disable iff (rst)
        !(main_lamp[0] && side_lamp[0]));

    assert_walk_all_red_R10: assert property (@(posedge clk) disable iff (rst)
        walk_on |-> (main_lamp == 3'b100 && side_lamp == 3'b100));

endmodule

bind junction_ctrl junction_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .main_demand (main_demand),
    .side_sensor (side_sensor),
    .walk_req    (walk_req),
    .expired     (phase_done),
    .main_lamp   (main_lamp),
    .side_lamp   (side_lamp),
    .walk_on     (walk_on),
    .phase       (phase)
);

// File: tb/test_junction_ctrl.sv
`timescale 1ns/1ps
module test_junction_ctrl;
    localparam int G = 8;
    localparam int A = 3;
    localparam int C = 2;
    localparam int RUN = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       main_demand = 1'b0;
    logic       side_sensor = 1'b0;
    logic       walk_req = 1'b0;
    logic [2:0] main_lamp;
    logic [2:0] side_lamp;
    logic       walk_on;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model state
    int m_ph;
    int m_cnt;
    // branch tallies
    int n_mg_my, n_mg_hold, n_my_ar, n_my_sg, n_ar_sg, n_sg_sy, n_sg_hold, n_sy_mg;
    logic [15:0] lf = 16'hACE1;

    always #5 clk = ~clk;

    junction_ctrl #(.GREEN_TICKS(G), .AMBER_TICKS(A), .CLEAR_TICKS(C)) i_junction_ctrl (
        .clk(clk), .rst(rst), .main_demand(main_demand), .side_sensor(side_sensor),
        .walk_req(walk_req), .main_lamp(main_lamp), .side_lamp(side_lamp),
        .walk_on(walk_on), .phase(phase)
    );

    function automatic int dwell(int p);
        if (p == 1 || p == 4) return A;
        if (p == 2) return C;
        return G;
    endfunction

    function automatic logic [2:0] exp_main(int p);
        return (p == 0) ? 3'b001 : (p == 1) ? 3'b010 : 3'b100;
    endfunction

    function automatic logic [2:0] exp_side(int p);
        return (p == 3) ? 3'b001 : (p == 4) ? 3'b010 : 3'b100;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic model_init();
        m_ph  = 0;
        m_cnt = G - 1;
    endtask

    // One clock edge of the reference model using the present input values.
    task automatic model_step();
        bit ex;
        int nx;
        if (rst) begin
            model_init();
            return;
        end
        ex = (m_cnt == 0);
        nx = m_ph;
        case (m_ph)
            0: if (main_demand && ex) begin nx = 1; n_mg_my++; end
               else if (ex) n_mg_hold++;
            1: if (ex) begin
                   nx = walk_req ? 2 : 3;
                   if (walk_req) n_my_ar++; else n_my_sg++;
               end
            2: if (ex) begin nx = 3; n_ar_sg++; end
            3: if (side_sensor && ex) begin nx = 4; n_sg_sy++; end
               else if (ex) n_sg_hold++;
            4: if (ex) begin nx = 0; n_sy_mg++; end
            default: nx = 0;
        endcase
        if (nx != m_ph) m_cnt = dwell(nx) - 1;
        else if (m_cnt != 0) m_cnt--;
        m_ph = nx;
    endtask

    task automatic compare_all();
        // R2..R8: phase sequence and dwell timing against the model
        check(int'(phase) == m_ph, "R2-R8 phase", phase, m_ph);
        check(main_lamp == exp_main(m_ph), "R9 main_lamp", main_lamp, exp_main(m_ph));
        check(side_lamp == exp_side(m_ph), "R9 side_lamp", side_lamp, exp_side(m_ph));
        check(walk_on == (m_ph == 2), "R10 walk_on", walk_on, int'(m_ph == 2));
        check(!(main_lamp[0] && side_lamp[0]), "R10 dual green", {main_lamp, side_lamp}, 0);
    endtask

    task automatic pick_inputs(int k);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (k < 400) begin
            main_demand = 1'b1;
            side_sensor = 1'b1;
            walk_req    = ((k / 60) % 2) == 1;
        end else if (k < 1200) begin
            main_demand = lf[0] & lf[1];
            side_sensor = lf[2];
            walk_req    = lf[3];
        end else if (k < 2000) begin
            main_demand = (lf[4:0] == 5'd0);
            side_sensor = (lf[7:5] == 3'd0);
            walk_req    = lf[8] | lf[9];
        end else begin
            main_demand = lf[1];
            side_sensor = lf[6];
            walk_req    = lf[11];
        end
        rst = (k == 2000) || (k == 2001);
    endtask

    initial begin
        n_mg_my = 0; n_mg_hold = 0; n_my_ar = 0; n_my_sg = 0;
        n_ar_sg = 0; n_sg_sy = 0; n_sg_hold = 0; n_sy_mg = 0;
        model_init();
        repeat (3) @(negedge clk);
        // R1: reset state
        check(phase == 3'd0, "R1 reset phase", phase, 0);
        check(main_lamp == 3'b001 && side_lamp == 3'b100, "R1 reset lamps",
              {main_lamp, side_lamp}, 6'b001100);
        rst = 1'b0;
        for (int k = 0; k < RUN; k++) begin
            if (k > 0) pick_inputs(k);
            @(negedge clk);
            model_step();
            compare_all();
            if (k == 2001) check(phase == 3'd0, "R1 mid-run reset", phase, 0);
        end
        // every branch must have been exercised
        check(n_mg_my   > 0, "R2 main green leave", n_mg_my, 1);
        check(n_mg_hold > 0, "R2 main green hold", n_mg_hold, 1);
        check(n_my_ar   > 0, "R3 amber to clearance", n_my_ar, 1);
        check(n_my_sg   > 0, "R4 amber to side green", n_my_sg, 1);
        check(n_ar_sg   > 0, "R5 clearance exit", n_ar_sg, 1);
        check(n_sg_sy   > 0, "R6 side green leave", n_sg_sy, 1);
        check(n_sg_hold > 0, "R6 side green hold", n_sg_hold, 1);
        check(n_sy_mg   > 0, "R7 side amber exit", n_sy_mg, 1);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule